// File: doc/BRIEF.md
# Global Barrier and Interrupt Combiner

This block is the per-node logic of a barrier and interrupt network that spans the nodes of a partition. It carries four independent channels. On each channel the node merges its own vote with the values coming up from its child links and passes the merged value to its parent. The global value then comes back down from the parent and is fanned out to the children. Each channel is set on its own to merge with OR, which suits interrupts, or with AND, which suits barriers. A sticky option keeps a channel asserted once it has fired, so that one channel is enough to complete a barrier.

A link mask decides which links belong to the node's partition. A masked child link is forced to the neutral value of the channel's operator, and a masked child also receives no downward value. The mask also has an uplink bit. When that bit is cleared the node acts as the root of its partition and turns its own merged value back down as the global value. Every incoming wire passes through a two-flop synchroniser. After that, merging is plain combinational gating. Software sets up and observes each channel through a small register port, and an interrupt output pulses when a channel's global value rises.

Top module: `gbi_combiner`

## Requirements
- R1: After reset every channel uses OR, has sticky off and has a local vote of 0. The link mask reads all ones (five bits: child links 0 to 3, then the uplink in bit 4). `up_out`, `irq` and `down_out` are all 0.
- R2: A channel in OR mode (mode bit 0) drives `up_out` to the OR of its local vote and its unmasked child bits, two clock edges after the child inputs change. Child bit for link l and channel c is `child_in[l*4+c]`.
- R3: A channel in AND mode (mode bit 1) drives `up_out` to the AND of its local vote and its unmasked child bits, with the same two-edge latency.
- R4: A child link whose mask bit is 0 has no effect on `up_out`. Its bit counts as 0 under OR and as 1 under AND.
- R5: With sticky enabled, once a channel's `up_out` is 1 it stays 1 after its inputs drop.
- R6: Writing a channel register with bit 3 set clears that channel's held state at that edge. From then on `up_out` follows the live merge.
- R7: With the uplink mask bit (bit 4) set, a channel's global value is `down_in` after two edges. With it cleared, the global value is the channel's own `up_out`.
- R8: `down_out[l*4+c]` equals channel c's global value when link l is unmasked, and is 0 when link l is masked.
- R9: `irq[c]` is 1 for exactly one cycle, which is the first cycle in which channel c's global value is 1 after having been 0.
- R10: Channel register c (address c, 0 to 3) is written through bit 0 mode, bit 1 sticky and bit 2 local vote. It reads back those bits plus bit 4 `up_out` and bit 5 global value; all other bits read 0. Address 4 writes and reads the link mask in bits 4:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| child_in | input | 16 | Asynchronous values from child links, bit l*4+c |
| down_in | input | 4 | Asynchronous global values from the parent |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| up_out | output | 4 | Merged value sent to the parent, one bit per channel |
| down_out | output | 16 | Global value sent to each child, bit l*4+c |
| irq | output | 4 | One-cycle pulse on a rising global value |

## Verification
Changes on `child_in` and `down_in` reach `up_out`, the global value and `down_out` on the second rising edge after they are driven. Register writes take effect on the first edge, and reads are combinational. The bench waits exactly that number of edges and samples half a period later. The interrupt is sampled in the same cycle the global value first shows 1, and again one edge later to confirm it has fallen. The sticky and clear checks first drop the inputs and confirm the channel holds, then confirm that the clear releases it on the next edge.

// File: rtl/gbi_pkg.sv
package gbi_pkg;

    // Merge operator of a channel.
    typedef enum logic {
        COMB_OR  = 1'b0,
        COMB_AND = 1'b1
    } comb_mode_e;

    // Per-channel configuration held in the register block.
    typedef struct packed {
        comb_mode_e mode;
        logic       sticky;
        logic       local_vote;
    } chan_cfg_t;

    // Channel register bit positions.
    localparam int CFG_MODE_BIT   = 0;
    localparam int CFG_STICKY_BIT = 1;
    localparam int CFG_LOCAL_BIT  = 2;
    localparam int CFG_CLEAR_BIT  = 3;
    localparam int STS_UP_BIT     = 4;
    localparam int STS_GLOB_BIT   = 5;

    // Value of a masked-off input: identity of the merge operator.
    function automatic logic neutral_of(comb_mode_e m);
        return (m == COMB_AND);
    endfunction

endpackage

// File: rtl/gbi_sync.sv
module gbi_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/gbi_regs.sv
module gbi_regs
    import gbi_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int NUM_LINKS = 4,
    parameter int ADDR_W    = 3,
    parameter int DATA_W    = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [ADDR_W-1:0]      rd_addr,
    input  logic [NUM_CH-1:0]      up,
    input  logic [NUM_CH-1:0]      glob,
    output logic [DATA_W-1:0]      rd_data,
    output chan_cfg_t [NUM_CH-1:0] cfg,
    output logic [NUM_LINKS:0]     mask,
    output logic [NUM_CH-1:0]      clr
);

    localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(NUM_CH);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NUM_CH; c++) begin
                cfg[c].mode       <= COMB_OR;
                cfg[c].sticky     <= 1'b0;
                cfg[c].local_vote <= 1'b0;
            end
            mask <= '1;
        end else if (wr_en) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (wr_addr == ADDR_W'(c)) begin
                    cfg[c].mode       <= comb_mode_e'(wr_data[CFG_MODE_BIT]);
                    cfg[c].sticky     <= wr_data[CFG_STICKY_BIT];
                    cfg[c].local_vote <= wr_data[CFG_LOCAL_BIT];
                end
            end
            if (wr_addr == MASK_ADDR) mask <= wr_data[NUM_LINKS:0];
        end
    end

    always_comb begin
        for (int c = 0; c < NUM_CH; c++)
            clr[c] = wr_en && (wr_addr == ADDR_W'(c)) && wr_data[CFG_CLEAR_BIT];
    end

    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_addr == ADDR_W'(c)) begin
                rd_data[CFG_MODE_BIT]   = cfg[c].mode;
                rd_data[CFG_STICKY_BIT] = cfg[c].sticky;
                rd_data[CFG_LOCAL_BIT]  = cfg[c].local_vote;
                rd_data[STS_UP_BIT]     = up[c];
                rd_data[STS_GLOB_BIT]   = glob[c];
            end
        end
        if (rd_addr == MASK_ADDR) rd_data[NUM_LINKS:0] = mask;
    end

    // R10: a mask write lands on the next edge
    a_r10_mask_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == MASK_ADDR) |=> (mask == $past(wr_data[NUM_LINKS:0])));

endmodule

// File: rtl/gbi_chan.sv
module gbi_chan
    import gbi_pkg::*;
#(
    parameter int NUM_LINKS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  chan_cfg_t            cfg,
    input  logic [NUM_LINKS-1:0] kids,
    input  logic [NUM_LINKS-1:0] kid_en,
    input  logic                 clr,
    input  logic                 down_s,
    input  logic                 uplink_en,
    output logic                 up,
    output logic                 glob,
    output logic                 irq
);

    logic [NUM_LINKS-1:0] eff_kids;
    logic                 raw;
    logic                 held_q;
    logic                 glob_q;

    assign eff_kids = (kids & kid_en) | (~kid_en & {NUM_LINKS{neutral_of(cfg.mode)}});

    always_comb begin
        if (cfg.mode == COMB_AND) raw = (&eff_kids) & cfg.local_vote;
        else                      raw = (|eff_kids) | cfg.local_vote;
    end

    always_ff @(posedge clk) begin
        if (rst || clr || !cfg.sticky) held_q <= 1'b0;
        else if (raw)                  held_q <= 1'b1;
    end

    assign up   = raw | (cfg.sticky & held_q);
    assign glob = uplink_en ? down_s : up;

    always_ff @(posedge clk) begin
        if (rst) glob_q <= 1'b0;
        else     glob_q <= glob;
    end

    assign irq = glob & ~glob_q;

    // R2: an OR channel with its own vote set is always asserted
    a_r2_or_local: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == COMB_OR && cfg.local_vote) |-> up);

    // R3: a non-sticky AND channel without its own vote never asserts
    a_r3_and_local: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == COMB_AND && !cfg.local_vote && !cfg.sticky) |-> !up);

    // R5: sticky channel stays up unless cleared or reconfigured
    a_r5_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        (cfg.sticky && up && !clr) |=> (up || !cfg.sticky));

    // R6: clear releases the held state
    a_r6_clear_release: assert property (@(posedge clk) disable iff (rst)
        clr |=> !held_q);

    // R9: interrupt lasts one cycle and marks a rise
    a_r9_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
    a_r9_irq_on_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(glob) |-> irq);

endmodule

// File: rtl/gbi_combiner.sv
module gbi_combiner
    import gbi_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int NUM_LINKS   = 4,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = $clog2(NUM_CH + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_LINKS*NUM_CH-1:0] child_in,
    input  logic [NUM_CH-1:0]           down_in,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [DATA_W-1:0]           rd_data,
    output logic [NUM_CH-1:0]           up_out,
    output logic [NUM_LINKS*NUM_CH-1:0] down_out,
    output logic [NUM_CH-1:0]           irq
);

    localparam int NK = NUM_LINKS * NUM_CH;

    logic [NK-1:0]             child_s;
    logic [NUM_CH-1:0]         down_s;
    chan_cfg_t [NUM_CH-1:0]    cfg;
    logic [NUM_LINKS:0]        mask;
    logic [NUM_CH-1:0]         clr;
    logic [NUM_CH-1:0]         glob;

    gbi_sync #(.WIDTH(NK), .STAGES(SYNC_STAGES)) u_sync_child (
        .clk (clk), .rst (rst), .d (child_in), .q (child_s)
    );

    gbi_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync_down (
        .clk (clk), .rst (rst), .d (down_in), .q (down_s)
    );

    gbi_regs #(
        .NUM_CH (NUM_CH), .NUM_LINKS (NUM_LINKS),
        .ADDR_W (ADDR_W), .DATA_W (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .up      (up_out),
        .glob    (glob),
        .rd_data (rd_data),
        .cfg     (cfg),
        .mask    (mask),
        .clr     (clr)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [NUM_LINKS-1:0] kids;
        for (genvar l = 0; l < NUM_LINKS; l++) begin : g_lk
            assign kids[l]                = child_s[l*NUM_CH + c];
            assign down_out[l*NUM_CH + c] = glob[c] & mask[l];
        end
        gbi_chan #(.NUM_LINKS(NUM_LINKS)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .cfg       (cfg[c]),
            .kids      (kids),
            .kid_en    (mask[NUM_LINKS-1:0]),
            .clr       (clr[c]),
            .down_s    (down_s[c]),
            .uplink_en (mask[NUM_LINKS]),
            .up        (up_out[c]),
            .glob      (glob[c]),
            .irq       (irq[c])
        );
    end

    // R8: nothing reaches a child that is outside the partition
    a_r8_down_isolated: assert property (@(posedge clk) disable iff (rst)
        (mask[0] == 1'b0) |-> (down_out[NUM_CH-1:0] == '0));

    // R1: outputs are quiet in the first cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> (up_out == '0 && irq == '0));

endmodule

// File: tb/test_gbi_combiner.sv
module test_gbi_combiner;

    localparam int NC = 4;
    localparam int NL = 4;
    localparam int NK = NC * NL;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NK-1:0] child_in = '0;
    logic [NC-1:0] down_in = '0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [2:0]    rd_addr = '0;
    logic [7:0]    rd_data;
    logic [NC-1:0] up_out;
    logic [NK-1:0] down_out;
    logic [NC-1:0] irq;

    gbi_combiner i_gbi_combiner (
        .clk (clk), .rst (rst), .child_in (child_in), .down_in (down_in),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .rd_addr (rd_addr), .rd_data (rd_data), .up_out (up_out),
        .down_out (down_out), .irq (irq)
    );

    always #10 clk = ~clk;

    typedef struct {
        int          kind;   // 0 up_out, 1 irq, 2 down_out, 3 rd_data
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;

    // monitor: pops expectations and compares
    initial begin
        forever begin
            wait (q.size() > 0);
            #1;
            begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.kind)
                    0:       act = 32'(up_out);
                    1:       act = 32'(irq);
                    2:       act = 32'(down_out);
                    default: act = 32'(rd_data);
                endcase
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic chk(int kind, logic [31:0] exp, string req);
        item_t it;
        it.kind = kind; it.exp = exp; it.req = req;
        q.push_back(it);
        #2;
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc(1);
        wr_en = 1'b0; wr_data = '0;
    endtask

    // reference merge for all channels, sticky off
    function automatic logic [NC-1:0] ref_up(logic [NK-1:0] kids, logic [NL-1:0] m,
                                             logic [NC-1:0] modes, logic [NC-1:0] locs);
        logic [NC-1:0] r;
        for (int c = 0; c < NC; c++) begin
            logic v;
            v = modes[c] ? locs[c] : locs[c];
            for (int l = 0; l < NL; l++) begin
                if (m[l]) v = modes[c] ? (v & kids[l*NC+c]) : (v | kids[l*NC+c]);
            end
            r[c] = v;
        end
        return r;
    endfunction

    function automatic logic [NK-1:0] fan_down(logic [NC-1:0] g, logic [NL-1:0] m);
        logic [NK-1:0] r;
        for (int l = 0; l < NL; l++)
            for (int c = 0; c < NC; c++) r[l*NC+c] = g[c] & m[l];
        return r;
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [NC-1:0] modes;
        logic [NC-1:0] locs;
        logic [NL-1:0] m;
        logic [NK-1:0] kids;

        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R1: reset state
        chk(0, 0, "R1 up_out");
        chk(1, 0, "R1 irq");
        chk(2, 0, "R1 down_out");
        rd_addr = 3'd4; chk(3, 32'h1F, "R1 mask");
        rd_addr = 3'd0; chk(3, 32'h00, "R1 ch0 cfg");

        // become partition root
        wr(3'd4, 8'h0F);

        // R2: OR merge with all channels default
        child_in = 16'h0021; cyc(2);
        chk(0, 32'(ref_up(16'h0021, 4'hF, 4'h0, 4'h0)), "R2 pattern a");
        child_in = 16'h8400; cyc(2);
        chk(0, 32'(ref_up(16'h8400, 4'hF, 4'h0, 4'h0)), "R2 pattern b");
        child_in = 16'h0000; cyc(2);
        chk(0, 0, "R2 all zero");

        // R3: mixed modes; ch0 AND, ch1 OR, ch2 AND+local, ch3 OR+local
        modes = 4'b0101; locs = 4'b1100;
        wr(3'd0, 8'h01); wr(3'd1, 8'h00); wr(3'd2, 8'h05); wr(3'd3, 8'h04);
        child_in = 16'hFFFF; cyc(2);
        chk(0, 32'(ref_up(16'hFFFF, 4'hF, modes, locs)), "R3 all ones");
        child_in = 16'hFFFB; cyc(2);
        chk(0, 32'(ref_up(16'hFFFB, 4'hF, modes, locs)), "R3 one child low");

        // R2/R3/R4 random children and masks against reference
        for (int i = 0; i < 24; i++) begin
            kids = 16'($urandom);
            m    = 4'($urandom);
            wr(3'd4, {4'h0, m});
            child_in = kids; cyc(2);
            chk(0, 32'(ref_up(kids, m, modes, locs)), "R3 R2 R4 random");
        end

        // R4: masked link 1 toggled has no effect
        wr(3'd4, 8'h0D);
        child_in = 16'hFF0F; cyc(2);
        chk(0, 32'(ref_up(16'hFF0F, 4'hD, modes, locs)), "R4 masked base");
        child_in = 16'hFFFF; cyc(2);
        chk(0, 32'(ref_up(16'hFF0F, 4'hD, modes, locs)), "R4 masked link high");
        child_in = 16'hFF0F; cyc(2);
        chk(0, 32'(ref_up(16'hFF0F, 4'hD, modes, locs)), "R4 masked link low");

        // R9: irq pulse on ch1 (OR, no local), root mode
        wr(3'd4, 8'h0F);
        wr(3'd0, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        child_in = 16'h0000; cyc(3);
        chk(1, 0, "R9 idle");
        child_in = 16'h0002; cyc(2);
        chk(1, 32'h2, "R9 pulse");
        cyc(1);
        chk(1, 0, "R9 pulse ends");
        chk(0, 32'h2, "R9 up held by input");
        child_in = 16'h0000; cyc(2);

        // R5: sticky on ch2
        wr(3'd2, 8'h02);
        child_in = 16'h0040; cyc(2);
        chk(0, 32'h4, "R5 sticky set");
        child_in = 16'h0000; cyc(3);
        chk(0, 32'h4, "R5 sticky holds");
        rd_addr = 3'd2;
        chk(3, 32'h32, "R10 ch2 status");
        // R6: clear
        wr(3'd2, 8'h0A);
        chk(0, 32'h0, "R6 cleared");
        cyc(1);
        chk(0, 32'h0, "R6 stays clear");

        // R7: uplink enabled, global follows down_in
        wr(3'd2, 8'h00);
        wr(3'd4, 8'h1F);
        down_in = 4'b1010; cyc(2);
        chk(2, 32'(fan_down(4'b1010, 4'hF)), "R7 R8 global from parent");
        rd_addr = 3'd1;
        chk(3, 32'h20, "R7 status glob");
        // R8: link 1 masked gets nothing
        wr(3'd4, 8'h1D);
        chk(2, 32'(fan_down(4'b1010, 4'hD)), "R8 masked link");
        // R7: root mode uses own merge
        wr(3'd4, 8'h0F);
        child_in = 16'h0001; cyc(2);
        chk(2, 32'(fan_down(4'b0001, 4'hF)), "R7 root own merge");

        // R10: readback
        wr(3'd3, 8'h05);
        rd_addr = 3'd3;
        chk(3, 32'h05, "R10 ch3 cfg");
        rd_addr = 3'd4;
        chk(3, 32'h0F, "R10 mask readback");

        wait (q.size() == 0);
        #3;
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule